// File: doc/BRIEF.md
# DDR SDRAM Mode Register Load Decoder

This block sits beside a DDR SDRAM device model or beside a controller's shadow copy of the device configuration. It watches the command bus. When a load-mode command appears, it stores the address word in one of two registers. With bank bit 0 low it is the base mode register. With bank bit 0 high it is the extended mode register. From the stored words it presents the active burst length, burst ordering, CAS latency, DLL on/off state and output drive strength as ready-decoded fields.

The base word has two parts. The low part holds the user settings. The upper bits, from A7 up to a parameterised top bit, pick the operating mode. If all of them are zero, the mode is normal. If only A8 is set, the command requests a DLL reset. Any other pattern is reserved or a test mode: the block refuses it and raises a flag. The block also raises a flag for codes that are not legal in the low part, and for reserved bits set in an extended write. It gives a one-cycle pulse when a DLL reset is accepted. It warns when the base-register load that follows a DLL reset does not select normal mode.

All outputs are registered. The effect of a command sampled at one rising clock edge is visible just after that edge.

Top module: `sdram_mode_decoder`

## Requirements
- R1: A load-mode command is `cmd_i` = 3'b000. With `bank_i` = 2'b00 it targets the base register, and with `bank_i` = 2'b01 it targets the extended register. Any other command code, or `bank_i[1]` = 1, changes no output.
- R2: In a base write, A2..A0 give the burst length: 001 gives 2, 010 gives 4 and 011 gives 8. `burst_len_o` shows the length as a number.
- R3: In a base write, A3 gives the burst ordering: 0 is sequential and 1 is interleaved. `burst_interleaved_o` shows it.
- R4: In a base write, A6..A4 give the CAS latency: 010 gives 2 clocks and 110 gives 2.5 clocks. `cas_latency_x2_o` shows twice the latency, so 4 or 5.
- R5: A base write with a non-reserved mode field but an illegal burst-length or latency code raises `err_illegal_o` for one cycle. It changes no setting and gives no DLL-reset pulse.
- R6: A base write whose mode field (A7..A12) has only A8 set is a DLL reset. Its low settings are applied, and `dll_reset_o` is high for exactly the one cycle after the command edge.
- R7: A base write whose mode field is neither all zero nor only A8 raises `err_reserved_o` for one cycle. Nothing is applied and no pulse is given. This includes A12, the top mode bit.
- R8: In an extended write, A0 = 1 disables the DLL (`dll_disabled_o`) and A1 = 1 selects reduced drive (`drive_reduced_o`). If any of A2..A12 is set, the write raises `err_reserved_o` for one cycle and is not applied.
- R9: After an accepted DLL reset, the next base write that is not a legal normal-mode load raises `warn_no_normal_o` for one cycle. Extended writes neither raise nor clear this pending check.
- R10: In reset, the outputs are: burst length 2, sequential, CAS latency 2, DLL enabled, full drive. The pulse, the flags and `configured_o` are low.
- R11: `configured_o` stays low until the first accepted base write, which may be a normal-mode load or a DLL reset. After that it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 3 | Command code; 3'b000 is load-mode |
| bank_i | input | 2 | Bank-address bits; bit 0 selects the register |
| addr_i | input | 13 | Address bus carrying the register word |
| burst_len_o | output | 4 | Burst length in beats |
| burst_interleaved_o | output | 1 | 1 for interleaved burst order |
| cas_latency_x2_o | output | 3 | CAS latency times two |
| dll_disabled_o | output | 1 | DLL switched off by the extended register |
| drive_reduced_o | output | 1 | Reduced output drive selected |
| dll_reset_o | output | 1 | One-cycle pulse on an accepted DLL reset |
| configured_o | output | 1 | A valid base load has been accepted |
| err_illegal_o | output | 1 | One-cycle flag: illegal low-field code |
| err_reserved_o | output | 1 | One-cycle flag: reserved or test-mode bits |
| warn_no_normal_o | output | 1 | One-cycle flag: DLL reset not followed by normal mode |

## Verification
Base writes are sent with each legal burst length, both burst orders and both latencies. This shows that every field is decoded from its own bits. Mode fields with A7 alone, with A8 and A9 together, and with A12 alone test the reserved check against the single-A8 DLL-reset pattern and the all-zero normal pattern. Illegal low codes are also sent, both under normal mode and under DLL reset, which shows that they are rejected without changing settings or giving a pulse. The test also sends extended writes, some with reserved bits, commands other than load-mode, and loads with bank bit 1 set. These show that writes go to the right register and that ignored commands leave every output unchanged. Finally, a DLL reset is followed by a second DLL reset, by an extended write and then by a normal load. This shows when the follow-up warning is raised, when it is held pending and when it is cleared.

// File: rtl/sdram_mode_pkg.sv
package sdram_mode_pkg;

    localparam int CMD_W = 3;
    localparam logic [CMD_W-1:0] CMD_LOAD_MODE = 3'b000;

    typedef enum logic [1:0] {
        OPM_NORMAL    = 2'd0,
        OPM_DLL_RESET = 2'd1,
        OPM_RESERVED  = 2'd2
    } op_mode_e;

    typedef struct packed {
        logic [3:0] burst_len;
        logic       interleaved;
        logic [2:0] cas_x2;
    } base_cfg_t;

    typedef struct packed {
        logic dll_off;
        logic weak_drive;
    } ext_cfg_t;

    localparam base_cfg_t BASE_RESET = '{burst_len: 4'd2, interleaved: 1'b0, cas_x2: 3'd4};
    localparam ext_cfg_t  EXT_RESET  = '{dll_off: 1'b0, weak_drive: 1'b0};

    // Burst length in beats; 0 marks an illegal code.
    function automatic logic [3:0] burst_from_code(input logic [2:0] code);
        case (code)
            3'b001:  return 4'd2;
            3'b010:  return 4'd4;
            3'b011:  return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

    // CAS latency doubled; 0 marks an illegal code.
    function automatic logic [2:0] cas_from_code(input logic [2:0] code);
        case (code)
            3'b010:  return 3'd4;
            3'b110:  return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/mode_word_decode.sv
module mode_word_decode
    import sdram_mode_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int OP_TOP = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output op_mode_e          mode_o,
    output base_cfg_t         cfg_o,
    output logic              low_ok_o
);
    localparam int OP_LO = 7;
    localparam int OP_W  = OP_TOP - OP_LO + 1;
    localparam logic [OP_W-1:0] DLL_PATTERN = OP_W'(2);

    logic [OP_W-1:0] op_field;
    logic [3:0]      bl;
    logic [2:0]      cl;

    assign op_field = addr_i[OP_TOP:OP_LO];
    assign bl       = burst_from_code(addr_i[2:0]);
    assign cl       = cas_from_code(addr_i[6:4]);

    always_comb begin
        if (op_field == '0)
            mode_o = OPM_NORMAL;
        else if (op_field == DLL_PATTERN)
            mode_o = OPM_DLL_RESET;
        else
            mode_o = OPM_RESERVED;
    end

    assign cfg_o    = '{burst_len: bl, interleaved: addr_i[3], cas_x2: cl};
    assign low_ok_o = (bl != 4'd0) && (cl != 3'd0);
endmodule

// File: rtl/ext_word_decode.sv
module ext_word_decode
    import sdram_mode_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int OP_TOP = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output ext_cfg_t          cfg_o,
    output logic              reserved_o
);
    assign cfg_o      = '{dll_off: addr_i[0], weak_drive: addr_i[1]};
    assign reserved_o = |addr_i[OP_TOP:2];
endmodule

// File: rtl/dll_follow_check.sv
module dll_follow_check (
    input  logic clk,
    input  logic rst,
    input  logic base_wr_i,
    input  logic dll_accept_i,
    input  logic normal_ok_i,
    output logic warn_o
);
    logic pending_q;
    logic warn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            warn_q    <= 1'b0;
        end else begin
            warn_q <= base_wr_i && pending_q && !normal_ok_i;
            if (base_wr_i)
                pending_q <= dll_accept_i;
        end
    end

    assign warn_o = warn_q;

    // R9: a warning is only ever the result of a base-register write
    assert_warn_after_base_write_R9: assert property (@(posedge clk) disable iff (rst)
        warn_q |-> $past(base_wr_i));
endmodule

// File: rtl/sdram_mode_decoder.sv
module sdram_mode_decoder
    import sdram_mode_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int OP_TOP = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [1:0]        bank_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [3:0]        burst_len_o,
    output logic              burst_interleaved_o,
    output logic [2:0]        cas_latency_x2_o,
    output logic              dll_disabled_o,
    output logic              drive_reduced_o,
    output logic              dll_reset_o,
    output logic              configured_o,
    output logic              err_illegal_o,
    output logic              err_reserved_o,
    output logic              warn_no_normal_o
);
    op_mode_e  base_mode;
    base_cfg_t base_new;
    logic      base_low_ok;
    ext_cfg_t  ext_new;
    logic      ext_reserved;

    logic is_load, base_wr, ext_wr;
    logic base_apply, dll_accept, normal_ok;

    base_cfg_t base_q;
    ext_cfg_t  ext_q;
    logic      configured_q, pulse_q, illegal_q, reserved_q;

    mode_word_decode #(.ADDR_W(ADDR_W), .OP_TOP(OP_TOP)) u_base_dec (
        .addr_i   (addr_i),
        .mode_o   (base_mode),
        .cfg_o    (base_new),
        .low_ok_o (base_low_ok)
    );

    ext_word_decode #(.ADDR_W(ADDR_W), .OP_TOP(OP_TOP)) u_ext_dec (
        .addr_i     (addr_i),
        .cfg_o      (ext_new),
        .reserved_o (ext_reserved)
    );

    assign is_load    = (cmd_i == CMD_LOAD_MODE) && !bank_i[1];
    assign base_wr    = is_load && !bank_i[0];
    assign ext_wr     = is_load && bank_i[0];
    assign base_apply = base_wr && (base_mode != OPM_RESERVED) && base_low_ok;
    assign dll_accept = base_wr && (base_mode == OPM_DLL_RESET) && base_low_ok;
    assign normal_ok  = (base_mode == OPM_NORMAL) && base_low_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q       <= BASE_RESET;
            ext_q        <= EXT_RESET;
            configured_q <= 1'b0;
            pulse_q      <= 1'b0;
            illegal_q    <= 1'b0;
            reserved_q   <= 1'b0;
        end else begin
            pulse_q    <= dll_accept;
            illegal_q  <= base_wr && (base_mode != OPM_RESERVED) && !base_low_ok;
            reserved_q <= (base_wr && (base_mode == OPM_RESERVED)) || (ext_wr && ext_reserved);
            if (base_apply) begin
                base_q       <= base_new;
                configured_q <= 1'b1;
            end
            if (ext_wr && !ext_reserved)
                ext_q <= ext_new;
        end
    end

    dll_follow_check u_follow (
        .clk          (clk),
        .rst          (rst),
        .base_wr_i    (base_wr),
        .dll_accept_i (dll_accept),
        .normal_ok_i  (normal_ok),
        .warn_o       (warn_no_normal_o)
    );

    assign burst_len_o         = base_q.burst_len;
    assign burst_interleaved_o = base_q.interleaved;
    assign cas_latency_x2_o    = base_q.cas_x2;
    assign dll_disabled_o      = ext_q.dll_off;
    assign drive_reduced_o     = ext_q.weak_drive;
    assign dll_reset_o         = pulse_q;
    assign configured_o        = configured_q;
    assign err_illegal_o       = illegal_q;
    assign err_reserved_o      = reserved_q;

    // R1: an extended-register load leaves the base settings alone
    assert_ext_keeps_base_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_LOAD_MODE && bank_i == 2'b01) |=> $stable(base_q));

    // R4: only the two legal latencies can ever be presented
    assert_cas_legal_R4: assert property (@(posedge clk) disable iff (rst)
        (cas_latency_x2_o == 3'd4) || (cas_latency_x2_o == 3'd5));

    // R5: a rejected low field leaves the base settings untouched
    assert_illegal_holds_base_R5: assert property (@(posedge clk) disable iff (rst)
        err_illegal_o |-> $stable(base_q));

    // R6: the reset pulse follows a base-register load on the previous edge
    assert_dll_pulse_source_R6: assert property (@(posedge clk) disable iff (rst)
        dll_reset_o |-> $past(cmd_i == CMD_LOAD_MODE && bank_i == 2'b00));

    // R7: a reserved pattern never produces a DLL-reset pulse
    assert_reserved_no_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        err_reserved_o |-> !dll_reset_o);

    // R11: configured never drops outside reset
    assert_configured_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        configured_o |=> configured_o);
endmodule

// File: tb/sdram_mode_decoder_test.sv
module sdram_mode_decoder_test;

    typedef struct packed {
        logic [2:0]  cmd;
        logic [1:0]  bank;
        logic [12:0] addr;
        logic [14:0] exp;   // {bl, il, cas, off, weak, pulse, ill, res, warn, cfg}
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{3'b111, 2'b00, 13'h032,  {4'd2, 1'b0, 3'd4, 2'b00, 5'b00000}, "R1 "},  // non-load ignored
        '{3'b000, 2'b00, 13'h06A,  {4'd4, 1'b1, 3'd5, 2'b00, 5'b00001}, "R2 "},  // BL4 interleaved CL2.5
        '{3'b000, 2'b00, 13'h023,  {4'd8, 1'b0, 3'd4, 2'b00, 5'b00001}, "R4 "},  // BL8 seq CL2
        '{3'b000, 2'b00, 13'h024,  {4'd8, 1'b0, 3'd4, 2'b00, 5'b01001}, "R5 "},  // bad BL code
        '{3'b000, 2'b00, 13'h032,  {4'd8, 1'b0, 3'd4, 2'b00, 5'b01001}, "R5 "},  // bad CL code
        '{3'b000, 2'b01, 13'h003,  {4'd8, 1'b0, 3'd4, 2'b11, 5'b00001}, "R8 "},  // ext: dll off, weak
        '{3'b000, 2'b01, 13'h005,  {4'd8, 1'b0, 3'd4, 2'b11, 5'b00101}, "R8 "},  // ext reserved A2
        '{3'b000, 2'b01, 13'h000,  {4'd8, 1'b0, 3'd4, 2'b00, 5'b00001}, "R8 "},  // ext cleared
        '{3'b000, 2'b00, 13'h161,  {4'd2, 1'b0, 3'd5, 2'b00, 5'b10001}, "R6 "},  // DLL reset
        '{3'b000, 2'b00, 13'h022,  {4'd4, 1'b0, 3'd4, 2'b00, 5'b00001}, "R9 "},  // normal follows
        '{3'b000, 2'b00, 13'h0A3,  {4'd4, 1'b0, 3'd4, 2'b00, 5'b00101}, "R7 "},  // A7 reserved
        '{3'b000, 2'b00, 13'h322,  {4'd4, 1'b0, 3'd4, 2'b00, 5'b00101}, "R7 "},  // A8+A9 reserved
        '{3'b000, 2'b00, 13'h122,  {4'd4, 1'b0, 3'd4, 2'b00, 5'b10001}, "R6 "},  // DLL reset
        '{3'b000, 2'b00, 13'h123,  {4'd8, 1'b0, 3'd4, 2'b00, 5'b10011}, "R9 "},  // second reset warns
        '{3'b000, 2'b01, 13'h001,  {4'd8, 1'b0, 3'd4, 2'b10, 5'b00001}, "R9 "},  // ext keeps pending
        '{3'b000, 2'b00, 13'h029,  {4'd2, 1'b1, 3'd4, 2'b10, 5'b00001}, "R3 "},  // normal clears
        '{3'b000, 2'b10, 13'h062,  {4'd2, 1'b1, 3'd4, 2'b10, 5'b00001}, "R1 "},  // bank bit 1 ignored
        '{3'b001, 2'b01, 13'h023,  {4'd2, 1'b1, 3'd4, 2'b10, 5'b00001}, "R1 "},  // other cmd ignored
        '{3'b000, 2'b00, 13'h124,  {4'd2, 1'b1, 3'd4, 2'b10, 5'b01001}, "R5 "},  // DLL reset, bad BL
        '{3'b000, 2'b00, 13'h1022, {4'd2, 1'b1, 3'd4, 2'b10, 5'b00101}, "R7 "}   // A12 reserved
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd_i = 3'b111;
    logic [1:0]  bank_i = 2'b00;
    logic [12:0] addr_i = '0;
    logic [3:0]  burst_len_o;
    logic        burst_interleaved_o;
    logic [2:0]  cas_latency_x2_o;
    logic        dll_disabled_o, drive_reduced_o, dll_reset_o, configured_o;
    logic        err_illegal_o, err_reserved_o, warn_no_normal_o;
    logic [14:0] obs;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sdram_mode_decoder uut (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .addr_i(addr_i),
        .burst_len_o(burst_len_o), .burst_interleaved_o(burst_interleaved_o),
        .cas_latency_x2_o(cas_latency_x2_o), .dll_disabled_o(dll_disabled_o),
        .drive_reduced_o(drive_reduced_o), .dll_reset_o(dll_reset_o),
        .configured_o(configured_o), .err_illegal_o(err_illegal_o),
        .err_reserved_o(err_reserved_o), .warn_no_normal_o(warn_no_normal_o)
    );

    assign obs = {burst_len_o, burst_interleaved_o, cas_latency_x2_o, dll_disabled_o,
                  drive_reduced_o, dll_reset_o, err_illegal_o, err_reserved_o,
                  warn_no_normal_o, configured_o};

    task automatic check(input logic [14:0] exp, input string tag);
        checks++;
        if (obs !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, obs, exp);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, then release.
    task automatic apply(input logic [2:0] c, input logic [1:0] b, input logic [12:0] a);
        cmd_i  = c;
        bank_i = b;
        addr_i = a;
        @(negedge clk);
        cmd_i  = 3'b111;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({4'd2, 1'b0, 3'd4, 2'b00, 5'b00000}, "R10 initial reset");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].cmd, VECS[i].bank, VECS[i].addr);
            check(VECS[i].exp, $sformatf("%s vector %0d", VECS[i].tag, i));
        end

        // R10: reset mid-run restores defaults
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check({4'd2, 1'b0, 3'd4, 2'b00, 5'b00000}, "R10 reset defaults");
        rst = 1'b0;

        // R11: extended write alone does not configure
        apply(3'b000, 2'b01, 13'h003);
        check({4'd2, 1'b0, 3'd4, 2'b11, 5'b00000}, "R11 ext only");
        // R11: reserved base write does not configure
        apply(3'b000, 2'b00, 13'h0A2);
        check({4'd2, 1'b0, 3'd4, 2'b11, 5'b00100}, "R11 reserved base");
        // R6/R11: DLL reset configures and pulses
        apply(3'b000, 2'b00, 13'h122);
        check({4'd4, 1'b0, 3'd4, 2'b11, 5'b10001}, "R6 reset accepted");
        // R6: pulse lasts one cycle
        apply(3'b111, 2'b00, 13'h000);
        check({4'd4, 1'b0, 3'd4, 2'b11, 5'b00001}, "R6 pulse ends");
        // R9: illegal follow-up load warns; configured holds
        apply(3'b000, 2'b00, 13'h024);
        check({4'd4, 1'b0, 3'd4, 2'b11, 5'b01011}, "R9 illegal follow-up");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule